// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block gathers the interrupt sources of an audio processing core into one status word that a host reads. It also drives a single active-high interrupt line. The sources are:

- converter lock indications, one per channel;
- completion pulses for ramp-up, ramp-down and mute, one per channel;
- clip (overflow) pulses, one per channel;
- a set of GPIO pins.

Each status bit follows its own clearing rule. The lock bit follows the latest converter state. The three completion bits hold until the main word is read. The overflow and GPIO bits are live ORs of two secondary registers, and those registers have their own read strobes.

Completion is judged against configuration vectors. A channel vector selects the active channels for lock and ramp tracking. A separate vector selects the channels taking part in a mute. A channel outside the relevant vector never holds back completion.

Each GPIO pin passes through a synchronizer. It then has an enable bit, an edge-or-level mode bit and a polarity bit. An enable bit of 0 masks the pin from the aggregate GPIO bit only.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, the status word, the overflow register, the GPIO register and `irq` are all 0.
- R2: Status bit 0 (lock) rises one cycle after the "every active channel locked" condition becomes true. Channels with `ch_active` 0 are ignored, and with no active channel the condition is false.
- R3: When that all-locked condition falls, status bit 0 clears on the next cycle without any read.
- R4: Status bit 1 sets when every active channel has given a `rup_done_p` pulse since the bit last fired. Status bit 2 follows the same rule with `rdn_done_p`. Inactive channels are ignored.
- R5: Status bit 3 sets when every channel selected in `mute_sel` has given a `mute_done_p` pulse. Pulses on unselected channels do not count.
- R6: Status bits 0 to 3 hold until a cycle with `rd_status` high, which clears them. An event that sets a bit in that same cycle wins, so the bit stays 1.
- R7: A `clip_p` pulse sets the matching bit of `ovfl_status`, and that bit holds. Status bit 4 is the OR of `ovfl_status`. `rd_ovfl` clears `ovfl_status`, and `rd_status` leaves it alone.
- R8: For an edge-mode pin (`gpio_lvl`=0), a change of the synchronized input to the level selected by `gpio_pol` (1 = high) sets its `gpio_status` bit. The bit appears three cycles after the pin changes. `rd_gpio` clears the bit and `rd_status` does not.
- R9: For a level-mode pin (`gpio_lvl`=1), the `gpio_status` bit stays 1 through `rd_gpio` while the input sits at the active level. Once the input has left that level, the next `rd_gpio` clears the bit.
- R10: Status bit 5 is the OR of the `gpio_status` bits whose `gpio_en` bit is 1. A masked pin still records its event in `gpio_status`.
- R11: `irq` is high exactly when some status bit is 1 while its `irq_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_active | input | NUM_CH | Channels taking part in lock and ramp checks |
| src_locked | input | NUM_CH | Per-channel converter lock level |
| rup_done_p | input | NUM_CH | Per-channel ramp-up finished pulse |
| rdn_done_p | input | NUM_CH | Per-channel ramp-down finished pulse |
| mute_sel | input | NUM_CH | Channels taking part in the mute |
| mute_done_p | input | NUM_CH | Per-channel mute cycle-down finished pulse |
| clip_p | input | NUM_CH | Per-channel clip pulse |
| gpio_pin | input | NUM_GPIO | Asynchronous GPIO inputs |
| gpio_en | input | NUM_GPIO | 1 = pin counts toward status bit 5 |
| gpio_lvl | input | NUM_GPIO | 1 = level mode, 0 = edge mode |
| gpio_pol | input | NUM_GPIO | 1 = active high or rising, 0 = active low or falling |
| irq_en | input | 6 | Per-status-bit interrupt enable |
| rd_status | input | 1 | Read strobe for the status word |
| rd_ovfl | input | 1 | Read strobe for the overflow register |
| rd_gpio | input | 1 | Read strobe for the GPIO register |
| status | output | 6 | Bit 0 lock, 1 ramp-up, 2 ramp-down, 3 mute, 4 overflow, 5 GPIO |
| ovfl_status | output | NUM_CH | Per-channel sticky clip flags |
| gpio_status | output | NUM_GPIO | Per-pin GPIO event flags |
| irq | output | 1 | Interrupt request |

## Verification
The sharpest overlap is a status read that falls in the same cycle as the final ramp-up completion pulse. The bench provokes it by raising the last active channel's pulse and `rd_status` in the same cycle, after the other channels have already reported. It passes when the bit is still 1 afterwards and a later plain read clears it. A second overlap is a GPIO read while a level-mode pin is held active; the bit must survive that read and fall only on a read after the pin is released.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ST_W    = 6;
   localparam int ST_LOCK = 0;
   localparam int ST_RUP  = 1;
   localparam int ST_RDN  = 2;
   localparam int ST_MUTE = 3;
   localparam int ST_OVF  = 4;
   localparam int ST_GPIO = 5;
   localparam int N_STICKY = 3;
endpackage

// File: rtl/irq_done_tracker.sv
module irq_done_tracker #(
   parameter int N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] watch,
   input  logic [N_CH-1:0] done_p,
   output logic            fire
);
   logic [N_CH-1:0] seen_q;
   logic [N_CH-1:0] seen_nxt;

   always_comb begin
      seen_nxt = (seen_q | done_p) & watch;
      fire     = (|watch) && (&(seen_nxt | ~watch));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_q <= '0;
      else if (fire) seen_q <= '0;
      else           seen_q <= seen_nxt;
   end

   AST_NO_FIRE_UNWATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (watch == '0) |-> !fire);  // R5
endmodule

// File: rtl/irq_gpio_capture.sv
module irq_gpio_capture #(
   parameter int N_PIN       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_in,
   input  logic [N_PIN-1:0] lvl_mode,
   input  logic [N_PIN-1:0] act_high,
   input  logic             clr,
   output logic [N_PIN-1:0] stat
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_gpio_capture: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < N_PIN; g++) begin : g_pin
      logic [SYNC_STAGES-1:0] sh_q;
      logic prev_q, stat_q, synced, active, prev_active, hit;

      always_comb begin
         synced      = sh_q[SYNC_STAGES-1];
         active      = (synced == act_high[g]);
         prev_active = (prev_q == act_high[g]);
         hit         = lvl_mode[g] ? active : (active && !prev_active);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            sh_q   <= {sh_q[SYNC_STAGES-2:0], pin_in[g]};
            prev_q <= synced;
            stat_q <= (stat_q && !clr) || hit;
         end
      end

      assign stat[g] = stat_q;

      AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_mode[g] && active) |=> stat_q);  // R9
      AST_EDGE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_mode[g] && clr && !hit) |=> !stat_q);  // R8
   end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int NUM_GPIO    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   ch_active,
   input  logic [NUM_CH-1:0]   src_locked,
   input  logic [NUM_CH-1:0]   rup_done_p,
   input  logic [NUM_CH-1:0]   rdn_done_p,
   input  logic [NUM_CH-1:0]   mute_sel,
   input  logic [NUM_CH-1:0]   mute_done_p,
   input  logic [NUM_CH-1:0]   clip_p,
   input  logic [NUM_GPIO-1:0] gpio_pin,
   input  logic [NUM_GPIO-1:0] gpio_en,
   input  logic [NUM_GPIO-1:0] gpio_lvl,
   input  logic [NUM_GPIO-1:0] gpio_pol,
   input  logic [ST_W-1:0]     irq_en,
   input  logic                rd_status,
   input  logic                rd_ovfl,
   input  logic                rd_gpio,
   output logic [ST_W-1:0]     status,
   output logic [NUM_CH-1:0]   ovfl_status,
   output logic [NUM_GPIO-1:0] gpio_status,
   output logic                irq
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("irq_status_agg: NUM_CH must be at least 1");
   end
   if (NUM_GPIO < 1) begin : g_bad_gpio
      $error("irq_status_agg: NUM_GPIO must be at least 1");
   end

   // lock tracking
   logic lock_all, lock_prev_q, lock_q, lock_rise, lock_fall;

   always_comb begin
      lock_all  = (|ch_active) && (&(src_locked | ~ch_active));
      lock_rise = lock_all && !lock_prev_q;
      lock_fall = !lock_all && lock_prev_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_prev_q <= 1'b0;
         lock_q      <= 1'b0;
      end else begin
         lock_prev_q <= lock_all;
         if (lock_rise)                   lock_q <= 1'b1;
         else if (lock_fall || rd_status) lock_q <= 1'b0;
      end
   end

   // completion trackers: ramp-up, ramp-down, mute
   logic [N_STICKY-1:0] fire;
   logic [N_STICKY-1:0] sticky_q;
   logic [NUM_CH-1:0]   trk_watch [N_STICKY];
   logic [NUM_CH-1:0]   trk_done  [N_STICKY];

   always_comb begin
      trk_watch[0] = ch_active;  trk_done[0] = rup_done_p;
      trk_watch[1] = ch_active;  trk_done[1] = rdn_done_p;
      trk_watch[2] = mute_sel;   trk_done[2] = mute_done_p;
   end

   for (genvar k = 0; k < N_STICKY; k++) begin : g_trk
      irq_done_tracker #(.N_CH(NUM_CH)) u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .watch  (trk_watch[k]),
         .done_p (trk_done[k]),
         .fire   (fire[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sticky_q[k] <= 1'b0;
         else        sticky_q[k] <= fire[k] || (sticky_q[k] && !rd_status);
      end
   end

   // per-channel clip flags
   logic [NUM_CH-1:0] ovfl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovfl_q <= '0;
      else        ovfl_q <= clip_p | (ovfl_q & ~{NUM_CH{rd_ovfl}});
   end

   // GPIO capture
   irq_gpio_capture #(.N_PIN(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)) u_gpio (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (gpio_pin),
      .lvl_mode (gpio_lvl),
      .act_high (gpio_pol),
      .clr      (rd_gpio),
      .stat     (gpio_status)
   );

   // aggregation
   always_comb begin
      status          = '0;
      status[ST_LOCK] = lock_q;
      status[ST_RUP]  = sticky_q[0];
      status[ST_RDN]  = sticky_q[1];
      status[ST_MUTE] = sticky_q[2];
      status[ST_OVF]  = |ovfl_q;
      status[ST_GPIO] = |(gpio_status & gpio_en);
      irq             = |(status & irq_en);
   end

   assign ovfl_status = ovfl_q;

   AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      lock_rise |=> status[ST_LOCK]);  // R2
   AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      lock_fall |=> !status[ST_LOCK]);  // R3
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_RUP] && !rd_status) |=> status[ST_RUP]);  // R6
   AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[0] && rd_status) |=> status[ST_RUP]);  // R6
   AST_OVF_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ovfl && clip_p == '0) |=> (ovfl_status == '0));  // R7
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_OVF] && !rd_ovfl) |=> status[ST_OVF]);  // R7
endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NG = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0] ch_active = '0, src_locked = '0, rup_done_p = '0, rdn_done_p = '0;
   logic [NC-1:0] mute_sel = '0, mute_done_p = '0, clip_p = '0;
   logic [NG-1:0] gpio_pin = '0, gpio_en = '0, gpio_lvl = '0, gpio_pol = '0;
   logic [5:0] irq_en = '0;
   logic rd_status = 1'b0, rd_ovfl = 1'b0, rd_gpio = 1'b0;
   logic [5:0] status;
   logic [NC-1:0] ovfl_status;
   logic [NG-1:0] gpio_status;
   logic irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_agg #(.NUM_CH(NC), .NUM_GPIO(NG), .SYNC_STAGES(2)) u_irq_status_agg (
      .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .src_locked(src_locked),
      .rup_done_p(rup_done_p), .rdn_done_p(rdn_done_p), .mute_sel(mute_sel),
      .mute_done_p(mute_done_p), .clip_p(clip_p), .gpio_pin(gpio_pin),
      .gpio_en(gpio_en), .gpio_lvl(gpio_lvl), .gpio_pol(gpio_pol), .irq_en(irq_en),
      .rd_status(rd_status), .rd_ovfl(rd_ovfl), .rd_gpio(rd_gpio),
      .status(status), .ovfl_status(ovfl_status), .gpio_status(gpio_status), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_status();
      rd_status = 1'b1; tick(1); rd_status = 1'b0; tick(1);
   endtask

   task automatic read_ovfl();
      rd_ovfl = 1'b1; tick(1); rd_ovfl = 1'b0; tick(1);
   endtask

   task automatic read_gpio();
      rd_gpio = 1'b1; tick(1); rd_gpio = 1'b0; tick(1);
   endtask

   task automatic pulse_rup(input logic [NC-1:0] v);
      rup_done_p = v; tick(1); rup_done_p = '0; tick(1);
   endtask

   task automatic pulse_rdn(input logic [NC-1:0] v);
      rdn_done_p = v; tick(1); rdn_done_p = '0; tick(1);
   endtask

   task automatic pulse_mute(input logic [NC-1:0] v);
      mute_done_p = v; tick(1); mute_done_p = '0; tick(1);
   endtask

   task automatic pulse_clip(input logic [NC-1:0] v);
      clip_p = v; tick(1); clip_p = '0; tick(1);
   endtask

   task automatic t_reset();
      check("R1", "status after reset", 32'(status), 0);
      check("R1", "ovfl_status after reset", 32'(ovfl_status), 0);
      check("R1", "gpio_status after reset", 32'(gpio_status), 0);
      check("R1", "irq after reset", 32'(irq), 0);
   endtask

   task automatic t_lock();
      ch_active = 4'b0111;
      src_locked = 4'b0011; tick(2);
      check("R2", "lock with one active channel unlocked", 32'(status[0]), 0);
      src_locked = 4'b0111; tick(1);
      check("R2", "lock, inactive ch3 ignored", 32'(status[0]), 1);
      src_locked = 4'b0101; tick(1);
      check("R3", "lock dropped by unlock without read", 32'(status[0]), 0);
      src_locked = 4'b0111; tick(1);
      check("R2", "lock set again", 32'(status[0]), 1);
      read_status();
      check("R6", "lock cleared by status read", 32'(status[0]), 0);
      src_locked = '0; tick(1);
      ch_active = 4'b1111; tick(1);
   endtask

   task automatic t_ramp();
      ch_active = 4'b1111;
      pulse_rup(4'b0011);
      check("R4", "ramp-up with two channels pending", 32'(status[1]), 0);
      pulse_rup(4'b1100);
      check("R4", "ramp-up all active done", 32'(status[1]), 1);
      tick(3);
      check("R6", "ramp-up held without read", 32'(status[1]), 1);
      read_status();
      check("R6", "ramp-up cleared by read", 32'(status[1]), 0);
      ch_active = 4'b0101;
      pulse_rup(4'b0001);
      check("R4", "ramp-up waits for ch2", 32'(status[1]), 0);
      pulse_rup(4'b0100);
      check("R4", "ramp-up with inactive channels ignored", 32'(status[1]), 1);
      read_status();
      ch_active = 4'b1111;
      pulse_rdn(4'b1111);
      check("R4", "ramp-down all done", 32'(status[2]), 1);
      check("R4", "ramp-up untouched by ramp-down", 32'(status[1]), 0);
      read_status();
      check("R6", "ramp-down cleared by read", 32'(status[2]), 0);
   endtask

   task automatic t_set_vs_read();
      ch_active = 4'b1111;
      pulse_rup(4'b1111);
      pulse_rup(4'b0111);
      rup_done_p = 4'b1000; rd_status = 1'b1; tick(1);
      rup_done_p = '0;      rd_status = 1'b0; tick(1);
      check("R6", "completion in read cycle wins", 32'(status[1]), 1);
      read_status();
      check("R6", "later read clears", 32'(status[1]), 0);
   endtask

   task automatic t_mute();
      mute_sel = 4'b0110;
      pulse_mute(4'b0010);
      check("R5", "mute with ch2 pending", 32'(status[3]), 0);
      pulse_mute(4'b1001);
      check("R5", "unselected channels do not count", 32'(status[3]), 0);
      pulse_mute(4'b0100);
      check("R5", "mute all selected done", 32'(status[3]), 1);
      read_status();
      check("R6", "mute cleared by read", 32'(status[3]), 0);
   endtask

   task automatic t_ovfl();
      pulse_clip(4'b0100);
      check("R7", "ovfl_status ch2", 32'(ovfl_status), 32'h4);
      check("R7", "status ovfl bit", 32'(status[4]), 1);
      pulse_clip(4'b0001);
      check("R7", "ovfl_status accumulates", 32'(ovfl_status), 32'h5);
      read_status();
      check("R7", "status read leaves ovfl", 32'(status[4]), 1);
      read_ovfl();
      check("R7", "ovfl read clears register", 32'(ovfl_status), 0);
      check("R7", "ovfl bit drops", 32'(status[4]), 0);
   endtask

   task automatic t_gpio_edge();
      gpio_pin[0] = 1'b1; tick(4);
      check("R8", "rising edge pin0", 32'(gpio_status), 32'h1);
      check("R10", "gpio bit set", 32'(status[5]), 1);
      read_status();
      check("R8", "status read keeps gpio bit", 32'(status[5]), 1);
      read_gpio();
      check("R8", "gpio read clears edge bit while pin high", 32'(gpio_status), 0);
      gpio_pin[1] = 1'b1; tick(4);
      check("R8", "rising ignored on falling-polarity pin1", 32'(gpio_status), 0);
      gpio_pin[1] = 1'b0; tick(4);
      check("R8", "falling edge pin1", 32'(gpio_status), 32'h2);
      read_gpio();
      gpio_en = 4'b1011;
      gpio_pin[2] = 1'b1; tick(4);
      check("R10", "masked pin2 recorded", 32'(gpio_status), 32'h4);
      check("R10", "masked pin2 not in gpio bit", 32'(status[5]), 0);
      read_gpio();
      gpio_pin = '0; gpio_en = 4'b1111; tick(4);
   endtask

   task automatic t_gpio_level();
      gpio_pin[3] = 1'b1; tick(4);
      check("R9", "level pin3 active", 32'(gpio_status), 32'h8);
      read_gpio();
      check("R9", "level bit survives read while active", 32'(gpio_status), 32'h8);
      gpio_pin[3] = 1'b0; tick(4);
      check("R9", "level bit held after release", 32'(gpio_status), 32'h8);
      read_gpio();
      check("R9", "level bit cleared after release", 32'(gpio_status), 0);
   endtask

   task automatic t_irq();
      irq_en = '0;
      clip_p = 4'b0010; tick(1); clip_p = '0; tick(1);
      check("R11", "irq low when nothing enabled", 32'(irq), 0);
      irq_en = 6'b010000; tick(1);
      check("R11", "irq on enabled ovfl bit", 32'(irq), 1);
      irq_en = 6'b100000; tick(1);
      check("R11", "irq low on enabled but clear gpio bit", 32'(irq), 0);
      read_ovfl();
   endtask

   initial begin
      gpio_en  = 4'b1111;
      gpio_lvl = 4'b1000;
      gpio_pol = 4'b1101;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_lock();
      t_ramp();
      t_set_vs_read();
      t_mute();
      t_ovfl();
      t_gpio_edge();
      t_gpio_level();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule